// File: doc/BRIEF.md
# Two-Wire Command Port Slave

This block is a slave on a two-wire serial control bus made of a clock line and an open-drain data line. Both lines are sampled by a fast system clock. The block finds frame boundaries and shifts in an address byte. If the address matches, it acknowledges the master. It then either gathers a command frame from the master or streams a response frame back to it. The pad driver is modelled as a single output-enable: when it is high, the data line is pulled low.

A write frame carries a command byte and up to seven argument bytes. When the frame closes, the core sees a one-cycle strobe together with the byte count and the captured bytes. A read frame begins with a status byte whose top bit is the core's clear-to-send flag. The core's response bytes follow. A strap input selects one of two fixed device addresses.

Top module: `cmd_bus_slave`

## Requirements
- R1: A START (data falls while the clock is high) or a STOP (data rises while the clock is high) is detected on the synchronized lines. After reset, `sda_oe_o`, `cmd_valid_o` and `cmd_count_o` are all 0.
- R2: The byte after a START is a 7-bit address, MSB first, followed by a direction bit (1 read, 0 write). Bits are taken on clock rising edges. The address is 0010001b when `addr_sel_i`=0 and 1100011b when `addr_sel_i`=1.
- R3: A matched address byte, and each accepted written byte, is acknowledged by holding `sda_oe_o` high from the next clock falling edge to the following one.
- R4: On an address mismatch the slave drives nothing. It also raises no strobe until the next START or STOP.
- R5: Written bytes are kept in arrival order. Byte i (byte 0 is the command) appears on `cmd_bytes_o[8*i+7:8*i]`.
- R6: At most 8 bytes are accepted per write frame. A ninth or later byte gets no acknowledge and is not stored.
- R7: A STOP or a repeated START that closes a matched write frame holding at least one byte raises `cmd_valid_o` for one cycle, with `cmd_count_o` equal to the byte count. A frame with no data byte raises no strobe.
- R8: On a read, bits go out MSB first and change only after clock falling edges. Byte 0 is `{rsp_cts_i, rsp_flags_i}`, with the clear-to-send flag in bit 7.
- R9: Read byte k (1 to 15) is `rsp_data_i[8*(k-1)+7:8*(k-1)]`. Byte 16 and later read as 8'hFF, with the line released.
- R10: A read byte that the master does not acknowledge ends the transfer. The slave then leaves the line released until the next START or STOP.
- R11: A START that arrives without a STOP before it restarts address reception from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls the data line low |
| addr_sel_i | input | 1 | Strap that picks the device address |
| rsp_cts_i | input | 1 | Clear-to-send flag, returned in status bit 7 |
| rsp_flags_i | input | 7 | Remaining status bits |
| rsp_data_i | input | 8*(RD_MAX-1) | Response bytes 1 to RD_MAX-1 |
| cmd_valid_o | output | 1 | One-cycle strobe at the close of a write frame |
| cmd_count_o | output | clog2(WR_MAX+1) | Number of bytes in the frame |
| cmd_bytes_o | output | 8*WR_MAX | Captured command and argument bytes |

## Verification
The bench uses the defaults WR_MAX=8 and RD_MAX=16, so the write-limit and read-limit edges fall within one short frame each. Writes of nine and ten bytes reach the unacknowledged overflow. Eighteen-byte reads run past the sixteen-byte response into the released-line bytes. Random frames mix both strap values, matching and foreign addresses, and lengths on both sides of the write limit. Repeated STARTs are driven both in the middle of an address byte and between a write and a read.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_END,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } tw_state_e;
endpackage

// File: rtl/tw_sync_edge.sv
`timescale 1ns/1ps
module tw_sync_edge #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      last_q  <= RST_VAL;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign prev_o = last_q;
endmodule

// File: rtl/tw_frame_ctrl.sv
`timescale 1ns/1ps
module tw_frame_ctrl
  import tw_pkg::*;
#(
  parameter int RD_MAX = 16,
  parameter int IDX_W  = $clog2(RD_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sda_i,
  input  logic [6:0]       addr_i,
  input  logic             room_i,
  input  logic [7:0]       tx_byte_i,
  output logic             oe_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             byte_wr_o,
  output logic             wr_begin_o,
  output logic [7:0]       rx_byte_o
);
  localparam logic [IDX_W-1:0] RD_LIM = IDX_W'(RD_MAX);

  tw_state_e        state_q, state_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             addr_ph_q, addr_ph_d;
  logic             rd_q, rd_d;
  logic             mack_q, mack_d;
  logic             oe_q, oe_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             load_tx;

  always_comb begin
    state_d    = state_q;
    bit_d      = bit_q;
    sh_d       = sh_q;
    addr_ph_d  = addr_ph_q;
    rd_d       = rd_q;
    mack_d     = mack_q;
    oe_d       = oe_q;
    idx_d      = idx_q;
    load_tx    = 1'b0;
    byte_wr_o  = 1'b0;
    wr_begin_o = 1'b0;
    if (start_i) begin
      state_d   = ST_RX;
      bit_d     = 3'd0;
      addr_ph_d = 1'b1;
      rd_d      = 1'b0;
      oe_d      = 1'b0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_RX: if (scl_rise_i) begin
          sh_d  = {sh_q[6:0], sda_i};
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) state_d = ST_RX_END;
        end
        ST_RX_END: if (scl_fall_i) begin
          addr_ph_d = 1'b0;
          if (addr_ph_q) begin
            if (sh_q[7:1] == addr_i) begin
              oe_d       = 1'b1;
              state_d    = ST_ACK;
              rd_d       = sh_q[0];
              wr_begin_o = ~sh_q[0];
              idx_d      = '0;
            end else begin
              state_d = ST_SKIP;
            end
          end else if (room_i) begin
            oe_d      = 1'b1;
            state_d   = ST_ACK;
            byte_wr_o = 1'b1;
          end else begin
            state_d = ST_SKIP;
          end
        end
        ST_ACK: if (scl_fall_i) begin
          if (rd_q) begin
            load_tx = 1'b1;
          end else begin
            oe_d    = 1'b0;
            bit_d   = 3'd0;
            state_d = ST_RX;
          end
        end
        ST_TX: if (scl_fall_i) begin
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            oe_d    = 1'b0;
            state_d = ST_MACK;
          end else begin
            sh_d = {sh_q[6:0], 1'b1};
            oe_d = ~sh_q[6];
          end
        end
        ST_MACK: begin
          if (scl_rise_i) mack_d = ~sda_i;
          if (scl_fall_i) begin
            if (mack_q) load_tx = 1'b1;
            else        state_d = ST_SKIP;
          end
        end
        default: ;
      endcase
      if (load_tx) begin
        sh_d    = tx_byte_i;
        oe_d    = ~tx_byte_i[7];
        bit_d   = 3'd0;
        mack_d  = 1'b0;
        state_d = ST_TX;
        if (idx_q != RD_LIM) idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_q     <= 3'd0;
      sh_q      <= 8'd0;
      addr_ph_q <= 1'b0;
      rd_q      <= 1'b0;
      mack_q    <= 1'b0;
      oe_q      <= 1'b0;
      idx_q     <= '0;
    end else begin
      state_q   <= state_d;
      bit_q     <= bit_d;
      sh_q      <= sh_d;
      addr_ph_q <= addr_ph_d;
      rd_q      <= rd_d;
      mack_q    <= mack_d;
      oe_q      <= oe_d;
      idx_q     <= idx_d;
    end
  end

  assign oe_o      = oe_q;
  assign idx_o     = idx_q;
  assign rx_byte_o = sh_q;
endmodule

// File: rtl/tw_cmd_store.sv
`timescale 1ns/1ps
module tw_cmd_store #(
  parameter int WR_MAX = 8,
  parameter int CNT_W  = $clog2(WR_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_begin_i,
  input  logic                byte_wr_i,
  input  logic [7:0]          byte_i,
  input  logic                frame_end_i,
  output logic                room_o,
  output logic [WR_MAX*8-1:0] bytes_o,
  output logic [CNT_W-1:0]    count_o,
  output logic                valid_o
);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(WR_MAX);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             open_q, open_d;
  logic             valid_q, valid_d;

  assign room_o = (cnt_q < CNT_LIM);

  always_comb begin
    cnt_d   = cnt_q;
    open_d  = open_q;
    valid_d = 1'b0;
    if (wr_begin_i) begin
      cnt_d  = '0;
      open_d = 1'b1;
    end else if (byte_wr_i && room_o) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    if (frame_end_i) begin
      open_d  = 1'b0;
      valid_d = open_q && (cnt_q != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      open_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      open_q  <= open_d;
      valid_q <= valid_d;
    end
  end

  for (genvar i = 0; i < WR_MAX; i++) begin : g_slot
    logic [7:0] slot_q;
    logic       slot_en;
    assign slot_en = byte_wr_i && (cnt_q == CNT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= 8'd0;
      else if (slot_en) slot_q <= byte_i;
    end
    assign bytes_o[8*i +: 8] = slot_q;
  end

  assign count_o = cnt_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/cmd_bus_slave.sv
`timescale 1ns/1ps
module cmd_bus_slave #(
  parameter int         WR_MAX  = 8,
  parameter int         RD_MAX  = 16,
  parameter logic [6:0] ADDR_LO = 7'b0010001,
  parameter logic [6:0] ADDR_HI = 7'b1100011
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          scl_i,
  input  logic                          sda_i,
  output logic                          sda_oe_o,
  input  logic                          addr_sel_i,
  input  logic                          rsp_cts_i,
  input  logic [6:0]                    rsp_flags_i,
  input  logic [8*(RD_MAX-1)-1:0]       rsp_data_i,
  output logic                          cmd_valid_o,
  output logic [$clog2(WR_MAX+1)-1:0]   cmd_count_o,
  output logic [8*WR_MAX-1:0]           cmd_bytes_o
);
  localparam int IDX_W = $clog2(RD_MAX + 1);
  localparam int SEL_W = $clog2(RD_MAX);
  localparam int CNT_W = $clog2(WR_MAX + 1);
  localparam logic [IDX_W-1:0] RD_LIM = IDX_W'(RD_MAX);

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [1:0] pin_raw, pin_lvl, pin_prev;
  assign pin_raw = {sda_i, scl_i};
  for (genvar g = 0; g < 2; g++) begin : g_sync
    tw_sync_edge #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_core_n),
      .d_i   (pin_raw[g]),
      .lvl_o (pin_lvl[g]),
      .prev_o(pin_prev[g])
    );
  end

  logic scl_rise, scl_fall, start_evt, stop_evt, frame_end;
  assign scl_rise  = pin_lvl[0] & ~pin_prev[0];
  assign scl_fall  = ~pin_lvl[0] & pin_prev[0];
  assign start_evt = pin_lvl[0] & pin_prev[0] & pin_prev[1] & ~pin_lvl[1];
  assign stop_evt  = pin_lvl[0] & pin_prev[0] & ~pin_prev[1] & pin_lvl[1];
  assign frame_end = start_evt | stop_evt;

  logic [7:0] rd_bytes [RD_MAX];
  assign rd_bytes[0] = {rsp_cts_i, rsp_flags_i};
  for (genvar k = 1; k < RD_MAX; k++) begin : g_rsp
    assign rd_bytes[k] = rsp_data_i[8*(k-1) +: 8];
  end

  logic [IDX_W-1:0] tx_idx;
  logic [7:0]       tx_byte, rx_byte;
  logic [6:0]       my_addr;
  logic             room, byte_wr, wr_begin;

  assign my_addr = addr_sel_i ? ADDR_HI : ADDR_LO;
  assign tx_byte = (tx_idx < RD_LIM) ? rd_bytes[tx_idx[SEL_W-1:0]] : 8'hFF;

  tw_frame_ctrl #(.RD_MAX(RD_MAX), .IDX_W(IDX_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start_evt),
    .stop_i    (stop_evt),
    .sda_i     (pin_lvl[1]),
    .addr_i    (my_addr),
    .room_i    (room),
    .tx_byte_i (tx_byte),
    .oe_o      (sda_oe_o),
    .idx_o     (tx_idx),
    .byte_wr_o (byte_wr),
    .wr_begin_o(wr_begin),
    .rx_byte_o (rx_byte)
  );

  tw_cmd_store #(.WR_MAX(WR_MAX), .CNT_W(CNT_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_begin_i (wr_begin),
    .byte_wr_i  (byte_wr),
    .byte_i     (rx_byte),
    .frame_end_i(frame_end),
    .room_o     (room),
    .bytes_o    (cmd_bytes_o),
    .count_o    (cmd_count_o),
    .valid_o    (cmd_valid_o)
  );
endmodule

// File: rtl/tw_slave_chk.sv
`timescale 1ns/1ps
module tw_slave_chk #(
  parameter int WR_MAX = 8,
  parameter int CNT_W  = $clog2(WR_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_fall,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             oe,
  input logic             valid,
  input logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(WR_MAX);

  // R7
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R7
  strobe_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (count != '0));

  // R6
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_LIM);

  // R8
  drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !oe);
endmodule

bind cmd_bus_slave tw_slave_chk #(.WR_MAX(WR_MAX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .scl_fall (scl_fall),
  .start_evt(start_evt),
  .stop_evt (stop_evt),
  .oe       (sda_oe_o),
  .valid    (cmd_valid_o),
  .count    (cmd_count_o)
);

// File: tb/sim_cmd_bus_slave.sv
`timescale 1ns/1ps
module sim_cmd_bus_slave;
  localparam int WR_MAX = 8;
  localparam int RD_MAX = 16;
  localparam int CNT_W  = $clog2(WR_MAX + 1);
  localparam int Q      = 6;
  localparam logic [6:0] A_LO = 7'b0010001;
  localparam logic [6:0] A_HI = 7'b1100011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0, cts = 1'b0;
  logic [6:0] flags = 7'd0;
  logic [8*(RD_MAX-1)-1:0] rsp = '0;
  logic sda_oe, cmd_valid;
  logic [CNT_W-1:0] cmd_count;
  logic [8*WR_MAX-1:0] cmd_bytes;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  cmd_bus_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .rsp_cts_i(cts),
    .rsp_flags_i(flags), .rsp_data_i(rsp), .cmd_valid_o(cmd_valid),
    .cmd_count_o(cmd_count), .cmd_bytes_o(cmd_bytes)
  );

  int errs = 0, checks = 0, pulses = 0, cap_cnt = 0;
  logic [8*WR_MAX-1:0] cap_bytes = '0;

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      pulses    = pulses + 1;
      cap_cnt   = int'(cmd_count);
      cap_bytes = cmd_bytes;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic bus_bit(input bit b, output bit line);
    sda_m = b; wait_q(); scl_m = 1'b1; wait_q();
    line = sda_line; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    bit l;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], l);
    bus_bit(1'b1, l);
    acked = ~l;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    bit l;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, l);
      v[i] = l;
    end
    bus_bit(~give_ack, l);
  endtask

  function automatic logic [7:0] exp_rd(input int k);
    if (k == 0) return {cts, flags};
    else if (k < RD_MAX) return rsp[8*(k-1) +: 8];
    else return 8'hFF;
  endfunction

  // Write frame: n data bytes in data[8*i +: 8]; checks acks, strobe, count, bytes.
  task automatic wr_frame(input logic [6:0] addr, input int n,
                          input logic [8*10-1:0] data, input bit match);
    bit ack;
    int p0, exp_n;
    p0 = pulses;
    bus_start();
    send_byte({addr, 1'b0}, ack);
    chk(ack == match, match ? "R2 address ack" : "R4 foreign address no ack", ack, match);
    for (int i = 0; i < n; i++) begin
      send_byte(data[8*i +: 8], ack);
      if (!match)           chk(ack == 1'b0, "R4 ignored data no ack", ack, 0);
      else if (i < WR_MAX)  chk(ack == 1'b1, "R3 data byte ack", ack, 1);
      else                  chk(ack == 1'b0, "R6 overflow byte no ack", ack, 0);
    end
    bus_stop();
    repeat (12) @(negedge clk);
    exp_n = (n > WR_MAX) ? WR_MAX : n;
    if (match && n > 0) begin
      chk(pulses == p0 + 1, "R7 strobe at stop", pulses - p0, 1);
      chk(cap_cnt == exp_n, "R7 byte count", cap_cnt, exp_n);
      for (int i = 0; i < exp_n; i++)
        chk(cap_bytes[8*i +: 8] == data[8*i +: 8], "R5 stored byte",
            cap_bytes[8*i +: 8], data[8*i +: 8]);
    end else begin
      chk(pulses == p0, match ? "R7 empty frame no strobe" : "R4 no strobe",
          pulses - p0, 0);
    end
  endtask

  task automatic rd_frame(input logic [6:0] addr, input int n, input bit match);
    bit ack;
    logic [7:0] v;
    bus_start();
    send_byte({addr, 1'b1}, ack);
    chk(ack == match, match ? "R2 read address ack" : "R4 read foreign no ack", ack, match);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, v);
      if (!match)      chk(v == 8'hFF, "R4 released line", v, 8'hFF);
      else if (k == 0) chk(v == exp_rd(0), "R8 status byte", v, exp_rd(0));
      else             chk(v == exp_rd(k), "R9 response byte", v, exp_rd(k));
    end
    bus_stop();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [8*10-1:0] d;
    bit ack, l;
    logic [7:0] v;
    int p0;
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
    chk(cmd_valid == 1'b0, "R1 reset strobe", cmd_valid, 0);
    chk(cmd_count == '0, "R1 reset count", cmd_count, 0);

    // Directed writes, both straps (R2, R3, R5, R7)
    d = '0; d[23:0] = 24'h7E01A5;
    addr_sel = 1'b0; wr_frame(A_LO, 3, d, 1'b1);
    addr_sel = 1'b1; wr_frame(A_HI, 2, d, 1'b1);
    // R2 strap swap: the other address no longer matches
    wr_frame(A_LO, 2, d, 1'b0);
    // R6 limit exactly, then overflow
    for (int i = 0; i < 10; i++) d[8*i +: 8] = 8'(8'h30 + i);
    wr_frame(A_HI, 8, d, 1'b1);
    wr_frame(A_HI, 10, d, 1'b1);
    // R7 address-only write
    wr_frame(A_HI, 0, d, 1'b1);

    // Reads (R8, R9), including past the response length
    cts = 1'b1; flags = 7'h2A;
    for (int k = 0; k < RD_MAX - 1; k++) rsp[8*k +: 8] = 8'($urandom);
    addr_sel = 1'b0;
    rd_frame(A_LO, 3, 1'b1);
    rd_frame(A_LO, 18, 1'b1);
    cts = 1'b0; flags = 7'h05;
    rd_frame(A_LO, 1, 1'b1);
    rd_frame(A_HI, 2, 1'b0);

    // R10 master NACK, then one more byte clocked with no STOP
    bus_start();
    send_byte({A_LO, 1'b1}, ack);
    recv_byte(1'b0, v);
    chk(v == exp_rd(0), "R10 status before nack", v, exp_rd(0));
    recv_byte(1'b0, v);
    chk(v == 8'hFF, "R10 line released after nack", v, 8'hFF);
    chk(sda_oe == 1'b0, "R10 oe low after nack", sda_oe, 0);
    bus_stop();
    repeat (8) @(negedge clk);

    // R11 repeated START in the middle of an address byte
    p0 = pulses;
    bus_start();
    for (int i = 0; i < 4; i++) bus_bit(1'b1, l);
    bus_start();
    send_byte({A_LO, 1'b0}, ack);
    chk(ack == 1'b1, "R11 address after restart", ack, 1);
    send_byte(8'hC3, ack);
    bus_stop();
    repeat (12) @(negedge clk);
    chk(pulses == p0 + 1 && cap_cnt == 1 && cap_bytes[7:0] == 8'hC3,
        "R11 frame after restart", cap_bytes[7:0], 8'hC3);

    // R11 repeated START between write and read; R7 strobe at the restart
    p0 = pulses;
    bus_start();
    send_byte({A_LO, 1'b0}, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    bus_start();
    repeat (12) @(negedge clk);
    chk(pulses == p0 + 1, "R7 strobe at repeated start", pulses - p0, 1);
    chk(cap_cnt == 2, "R7 count at repeated start", cap_cnt, 2);
    send_byte({A_LO, 1'b1}, ack);
    chk(ack == 1'b1, "R11 read after restart", ack, 1);
    recv_byte(1'b1, v);
    chk(v == exp_rd(0), "R11 status after restart", v, exp_rd(0));
    recv_byte(1'b0, v);
    chk(v == exp_rd(1), "R9 byte after restart", v, exp_rd(1));
    bus_stop();
    repeat (12) @(negedge clk);
    chk(pulses == p0 + 1, "R7 no strobe for read frame", pulses - p0, 1);

    // Random write frames
    for (int it = 0; it < 20; it++) begin
      int n;
      bit m;
      logic [6:0] a;
      addr_sel = 1'($urandom);
      n = 1 + int'($urandom % 10);
      m = ($urandom % 5) != 0;
      a = addr_sel ? A_HI : A_LO;
      if (!m) a = a ^ 7'(1 + ($urandom % 127));
      for (int i = 0; i < 10; i++) d[8*i +: 8] = 8'($urandom);
      wr_frame(a, n, d, m);
    end

    summary();
  end
endmodule